// File: doc/BRIEF.md
# Bidirectional Event Trigger Bridge

This block moves single events between a host bus clock and a user clock, in both directions, for one inbound and one outbound 32-bit trigger word. When the host writes a word to the inbound address, every set bit becomes a pulse one user-clock cycle long on the matching output bit. In the other direction, each user event line is sampled on the user clock. A low sample followed by a high sample flags that bit. The flag is held in a sticky word that the host reads at the outbound address, and the read that returns it also clears it.

Both clock-domain crossings sit inside the block, along with the address decode on a simple host bus: address, write data, write strobe, read strobe and registered read data. Each direction crosses with one toggle flag per bit and a multi-flop synchroniser, with an edge detector on the far side. This carries the following timing contract. The host must space two writes that set the same bit at least four user cycles apart. The host clock must be no slower than the user clock, so that each user-side toggle is seen before it can flip back.

Top module: `trig_endpoint_bridge`

## Requirements
- R1: A host write to the inbound address (default 0x40) makes exactly one pulse on trig_pulse[i] for each data bit i that is 1, and no pulse on bits that are 0. Two writes to the same bit that meet the spacing rule give two separate pulses.
- R2: A pulse on any trig_pulse bit is high for exactly one user clock cycle.
- R3: A write to any other address, a write of all zeros, or any read causes no pulse on trig_pulse.
- R4: An outbound event on evt_in[i] counts only when the user-clock sample of that line is 0 on one edge and 1 on the next. A level held high is reported once. A high glitch that starts and ends between two user clock edges is not reported.
- R5: A read of the outbound address (default 0x60) returns the sticky word on host_rdata in the host cycle after the read strobe is sampled, and clears the returned bits. Until then, each set bit stays set.
- R6: Several rising edges on one event bit between two polls show up as a single set bit, and the next poll returns 0 for that bit.
- R7: An edge that reaches the sticky word in the same host cycle as a poll-clear is not lost. It is returned by the following poll.
- R8: host_rdata is all zeros except in the cycle after an outbound-address read. A read of any other address returns zero and leaves the sticky word unchanged.
- R9: hrst_n and urst_n are asynchronous active-low resets, released synchronously in their own domains. Together they clear every pending inbound toggle and every sticky bit. While reset is held, trig_pulse and host_rdata are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| hrst_n | input | 1 | Host-domain asynchronous active-low reset |
| host_addr | input | 8 | Bus address |
| host_wdata | input | 32 | Write data, one bit per inbound trigger |
| host_wr | input | 1 | Write strobe, one host cycle per access |
| host_rd | input | 1 | Read strobe, one host cycle per access |
| host_rdata | output | 32 | Registered read data |
| uclk | input | 1 | User clock |
| urst_n | input | 1 | User-domain asynchronous active-low reset |
| trig_pulse | output | 32 | One-cycle inbound pulses in the user domain |
| evt_in | input | 32 | User event lines, synchronous to uclk |

## Verification
Inbound words are written with one low bit, one high bit, alternating bit patterns, all ones and all zeros, and also with misdirected addresses. This separates wrong bit mapping, stuck or doubled pulses, and a loose address decode. On the outbound side, the bench uses a held level, a burst of repeated edges, a sub-cycle glitch and a multi-bit event. These separate true edge detection from level sensing, and collapsing from counting. A run of back-to-back polls forces an edge to land on a clear cycle, and a foreign-address read with a flag pending shows that reads do not disturb the sticky word.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned TRIG_WIDTH_DEF = 32;
  localparam int unsigned ADDR_WIDTH_DEF = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_IN   = 2'd1,
    SEL_OUT  = 2'd2
  } sel_e;
endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= src;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/trig_in_path.sv
module trig_in_path #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             hclk,
  input  logic             hrst_n,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wdata,
  input  logic             uclk,
  input  logic             urst_n,
  output logic [WIDTH-1:0] pulse
);
  // host domain: one toggle flag per bit
  logic [WIDTH-1:0] tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (wr_hit) tog_d = tog_q ^ wdata;
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) tog_q <= '0;
    else         tog_q <= tog_d;
  end

  // user domain: synchronise and detect any change
  logic [WIDTH-1:0] tog_s, prev_q;

  trig_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk  (uclk),
    .rst_n(urst_n),
    .d    (tog_q),
    .q    (tog_s)
  );

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) prev_q <= '0;
    else         prev_q <= tog_s;
  end

  assign pulse = tog_s ^ prev_q;

  // R3: toggles move only on an inbound write
  p_tog_hold_r3: assert property (@(posedge hclk) disable iff (!hrst_n)
    !wr_hit |=> $stable(tog_q));

  // R2: no bit pulses on two consecutive user cycles
  p_pulse_single_r2: assert property (@(posedge uclk) disable iff (!urst_n)
    (|pulse) |=> ((pulse & $past(pulse)) == '0));
endmodule

// File: rtl/trig_out_path.sv
module trig_out_path #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             uclk,
  input  logic             urst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             hclk,
  input  logic             hrst_n,
  input  logic             rd_hit,
  output logic [WIDTH-1:0] sticky
);
  // user domain: sample, edge detect, toggle
  logic [WIDTH-1:0] samp_q, hist_q, utog_q, utog_d, rise;

  assign rise = samp_q & ~hist_q;

  always_comb begin
    utog_d = utog_q ^ rise;
  end

  always_ff @(posedge uclk or negedge urst_n) begin
    if (!urst_n) begin
      samp_q <= '0;
      hist_q <= '0;
      utog_q <= '0;
    end else begin
      samp_q <= evt;
      hist_q <= samp_q;
      utog_q <= utog_d;
    end
  end

  // host domain: synchronise, detect change, hold until polled
  logic [WIDTH-1:0] hs, hprev_q, set, sticky_q, sticky_d;

  trig_sync #(.WIDTH(WIDTH), .STAGES(STAGES)) u_sync (
    .clk  (hclk),
    .rst_n(hrst_n),
    .d    (utog_q),
    .q    (hs)
  );

  assign set = hs ^ hprev_q;

  always_comb begin
    sticky_d = rd_hit ? '0 : sticky_q;
    sticky_d = sticky_d | set;
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      hprev_q  <= '0;
      sticky_q <= '0;
    end else begin
      hprev_q  <= hs;
      sticky_q <= sticky_d;
    end
  end

  assign sticky = sticky_q;

  // R5: without a poll, no flag is lost
  p_sticky_hold_r5: assert property (@(posedge hclk) disable iff (!hrst_n)
    !rd_hit |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

  // R7: a newly crossed edge is always held, even on a clear cycle
  p_edge_kept_r7: assert property (@(posedge hclk) disable iff (!hrst_n)
    (|set) |=> ((sticky_q & $past(set)) == $past(set)));
endmodule

// File: rtl/trig_endpoint_bridge.sv
module trig_endpoint_bridge
  import trig_pkg::*;
#(
  parameter int unsigned            WIDTH       = TRIG_WIDTH_DEF,
  parameter int unsigned            ADDR_W      = ADDR_WIDTH_DEF,
  parameter logic [ADDR_W-1:0]      IN_ADDR     = 'h40,
  parameter logic [ADDR_W-1:0]      OUT_ADDR    = 'h60,
  parameter int unsigned            SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WIDTH-1:0]  host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [WIDTH-1:0]  host_rdata,
  input  logic              uclk,
  input  logic              urst_n,
  output logic [WIDTH-1:0]  trig_pulse,
  input  logic [WIDTH-1:0]  evt_in
);
  logic h_rst_n, u_rst_n;

  trig_rst_sync #(.STAGES(2)) u_hrst (.clk(hclk), .arst_n(hrst_n), .rst_n(h_rst_n));
  trig_rst_sync #(.STAGES(2)) u_urst (.clk(uclk), .arst_n(urst_n), .rst_n(u_rst_n));

  // address decode
  sel_e sel;
  always_comb begin
    sel = SEL_NONE;
    if (host_addr == IN_ADDR)       sel = SEL_IN;
    else if (host_addr == OUT_ADDR) sel = SEL_OUT;
  end

  logic wr_hit, rd_hit;
  assign wr_hit = host_wr && (sel == SEL_IN);
  assign rd_hit = host_rd && (sel == SEL_OUT);

  trig_in_path #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in (
    .hclk  (hclk),
    .hrst_n(h_rst_n),
    .wr_hit(wr_hit),
    .wdata (host_wdata),
    .uclk  (uclk),
    .urst_n(u_rst_n),
    .pulse (trig_pulse)
  );

  logic [WIDTH-1:0] sticky;

  trig_out_path #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_out (
    .uclk  (uclk),
    .urst_n(u_rst_n),
    .evt   (evt_in),
    .hclk  (hclk),
    .hrst_n(h_rst_n),
    .rd_hit(rd_hit),
    .sticky(sticky)
  );

  // registered read port
  logic [WIDTH-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (rd_hit) rdata_d = sticky;
  end

  always_ff @(posedge hclk or negedge h_rst_n) begin
    if (!h_rst_n) rdata_q <= '0;
    else          rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;

  // R8: read data stays zero unless the outbound word was read
  p_rdata_idle_r8: assert property (@(posedge hclk) disable iff (!h_rst_n)
    !rd_hit |=> (host_rdata == '0));
endmodule

// File: tb/tb_trig_endpoint_bridge.sv
module tb_trig_endpoint_bridge;
  localparam int W = 32;

  typedef struct packed {
    logic [7:0]   a;
    logic [W-1:0] d;
    logic [W-1:0] m;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{a: 8'h40, d: 32'h0000_0001, m: 32'h0000_0001},
    '{a: 8'h40, d: 32'h8000_0000, m: 32'h8000_0000},
    '{a: 8'h40, d: 32'hA5A5_A5A5, m: 32'hA5A5_A5A5},
    '{a: 8'h40, d: 32'hFFFF_FFFF, m: 32'hFFFF_FFFF},
    '{a: 8'h40, d: 32'h0000_0000, m: 32'h0000_0000},
    '{a: 8'h41, d: 32'hFFFF_FFFF, m: 32'h0000_0000},
    '{a: 8'h60, d: 32'hFFFF_FFFF, m: 32'h0000_0000},
    '{a: 8'h40, d: 32'h5A5A_0F0F, m: 32'h5A5A_0F0F}
  };

  logic hclk = 1'b0, uclk = 1'b0;
  always #2 hclk = ~hclk;
  always #3 uclk = ~uclk;

  logic          hrst_n, urst_n;
  logic [7:0]    host_addr;
  logic [W-1:0]  host_wdata, host_rdata, trig_pulse, evt_in;
  logic          host_wr, host_rd;

  trig_endpoint_bridge dut (
    .hclk(hclk), .hrst_n(hrst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .uclk(uclk), .urst_n(urst_n), .trig_pulse(trig_pulse), .evt_in(evt_in)
  );

  int total = 0, bad = 0;
  int pcnt [W] = '{default: 0};
  int snap [W] = '{default: 0};
  int wide = 0;
  logic [W-1:0] pprev = '0;

  always @(negedge uclk) begin
    for (int b = 0; b < W; b++) if (trig_pulse[b] === 1'b1) pcnt[b]++;
    if ((trig_pulse & pprev) != '0) wide++;
    pprev = trig_pulse;
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic take_snap();
    for (int b = 0; b < W; b++) snap[b] = pcnt[b];
  endtask

  function automatic logic [W-1:0] delta_mask(input int n);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) r[b] = ((pcnt[b] - snap[b]) == n);
    return r;
  endfunction

  task automatic host_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge hclk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge hclk); host_wr = 1'b0;
  endtask

  task automatic poll(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge hclk); host_addr = a; host_rd = 1'b1;
    @(negedge hclk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic do_reset();
    hrst_n = 1'b0; urst_n = 1'b0;
    repeat (5) @(negedge uclk);
    chk("R9 pulse in reset", trig_pulse, '0);
    chk("R9 rdata in reset", host_rdata, '0);
    @(negedge hclk); hrst_n = 1'b1;
    @(negedge uclk); urst_n = 1'b1;
    repeat (6) @(negedge hclk);
  endtask

  initial begin
    logic [W-1:0] rd;
    int hits;
    host_addr = '0; host_wdata = '0; host_wr = 1'b0; host_rd = 1'b0; evt_in = '0;
    do_reset();

    // R1 / R3: table walk of inbound words
    for (int i = 0; i < NV; i++) begin
      take_snap();
      host_write(VEC[i].a, VEC[i].d);
      repeat (10) @(negedge uclk);
      chk($sformatf("R1/R3 vec%0d one pulse", i), delta_mask(1), VEC[i].m);
      chk($sformatf("R1/R3 vec%0d silent", i), delta_mask(0), ~VEC[i].m);
    end

    // R1: two spaced writes to one bit give two pulses
    take_snap();
    host_write(8'h40, 32'h0000_0010);
    repeat (8) @(negedge uclk);
    host_write(8'h40, 32'h0000_0010);
    repeat (10) @(negedge uclk);
    chk("R1 two writes two pulses", delta_mask(2), 32'h0000_0010);

    // R3: read of inbound address makes no pulse
    take_snap();
    poll(8'h40, rd);
    repeat (10) @(negedge uclk);
    chk("R3 read no pulse", delta_mask(0), '1);

    // R4 / R5: held level reported once, then cleared
    @(negedge uclk); evt_in[3] = 1'b1;
    repeat (10) @(negedge hclk);
    poll(8'h60, rd); chk("R4 edge reported", rd, 32'h0000_0008);
    poll(8'h60, rd); chk("R5 poll clears", rd, '0);
    repeat (10) @(negedge hclk);
    poll(8'h60, rd); chk("R4 level not re-reported", rd, '0);
    @(negedge uclk); evt_in[3] = 1'b0;

    // R4: glitch between uclk edges
    @(posedge uclk); #1 evt_in[7] = 1'b1; #1 evt_in[7] = 1'b0;
    repeat (10) @(negedge hclk);
    poll(8'h60, rd); chk("R4 glitch ignored", rd, '0);

    // R6: burst of edges collapses
    for (int k = 0; k < 3; k++) begin
      @(negedge uclk); evt_in[5] = 1'b1;
      repeat (2) @(negedge uclk); evt_in[5] = 1'b0;
      repeat (2) @(negedge uclk);
    end
    repeat (10) @(negedge hclk);
    poll(8'h60, rd); chk("R6 one report", rd, 32'h0000_0020);
    poll(8'h60, rd); chk("R6 nothing left", rd, '0);

    // R4: several bits at once
    @(negedge uclk); evt_in = 32'hF0F0_0001;
    repeat (3) @(negedge uclk); evt_in = '0;
    repeat (10) @(negedge hclk);
    poll(8'h60, rd); chk("R4 multi-bit", rd, 32'hF0F0_0001);

    // R8: foreign read returns zero and keeps the flag
    @(negedge uclk); evt_in[11] = 1'b1;
    repeat (3) @(negedge uclk); evt_in[11] = 1'b0;
    repeat (10) @(negedge hclk);
    poll(8'h40, rd); chk("R8 foreign read zero", rd, '0);
    @(negedge hclk); chk("R8 idle rdata", host_rdata, '0);
    poll(8'h60, rd); chk("R8 flag kept", rd, 32'h0000_0800);

    // R7: continuous polls force the edge onto a clear cycle
    hits = 0;
    @(negedge hclk); host_addr = 8'h60; host_rd = 1'b1;
    fork
      begin
        for (int k = 0; k < 30; k++) begin
          @(negedge hclk);
          if (host_rdata[9] === 1'b1) hits++;
        end
      end
      begin
        repeat (3) @(negedge uclk); evt_in[9] = 1'b1;
        repeat (3) @(negedge uclk); evt_in[9] = 1'b0;
      end
    join
    host_rd = 1'b0;
    @(negedge hclk); if (host_rdata[9] === 1'b1) hits++;
    chk("R7 edge on clear cycle reported once", 32'(hits), 32'd1);

    // R9: pending sticky cleared by reset
    @(negedge uclk); evt_in[2] = 1'b1;
    repeat (3) @(negedge uclk); evt_in[2] = 1'b0;
    repeat (10) @(negedge hclk);
    do_reset();
    poll(8'h60, rd); chk("R9 sticky cleared", rd, '0);

    // R9: pending inbound toggle cleared by reset
    take_snap();
    host_write(8'h40, 32'hFFFF_FFFF);
    do_reset();
    repeat (10) @(negedge uclk);
    chk("R9 no pulse after reset", delta_mask(0), '1);
    take_snap();
    host_write(8'h40, 32'h0000_0001);
    repeat (10) @(negedge uclk);
    chk("R9 clean restart", delta_mask(1), 32'h0000_0001);

    chk("R2 single-cycle pulses", 32'(wide), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule